// File: doc/BRIEF.md
# Inter-Processor Mailbox Doorbell

This block lets a host processor and an I/O processor exchange command descriptors through a small set of shared registers. Each processor has its own register port. To issue a request, the host stores the physical address of a command structure in the request pointer register. It then rings a doorbell bit in the shared flag register. The I/O processor sees an interrupt, services the command, stores the completed structure's address in the reply pointer register, and writes 0x14 to the flag register to announce the reply. That raises the host's interrupt.

The flag register is shared. Each flag bit belongs to one side. The owning side sets the bit by writing 1 to it. The receiving side acknowledges it by writing 1, which clears it. If a set and a clear of the same bit happen in the same cycle, the set wins.

Only the low address bits are decoded. The register window therefore repeats every window size across the whole port address range.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, both pointers, the flag register and both interrupt enables read as zero, and both interrupt outputs are low.
- R2: A host write to word offset 0x0 loads the request pointer. An I/O-processor write to word offset 0x8 loads the reply pointer. Both pointers read back identically from either port.
- R3: A pointer write whose data has bit 1 or bit 0 set is ignored.
- R4: A pointer can be written only by its owner. I/O-processor writes to 0x0 and host writes to 0x8 are ignored.
- R5: At flag offset 0x4, a host write of 1 sets host-owned bits 0 and 1. A written 0 leaves a bit unchanged.
- R6: An I/O-processor write of 0x14 to offset 0x4 sets reply bits 2 and 4. Bits 2 to 7 are owned by the I/O processor.
- R7: Writing 1 to a flag bit owned by the other side clears that bit.
- R8: When one flag bit is set and cleared in the same cycle, it ends up set.
- R9: The I/O-processor interrupt is high while flag bit 0 is set and the I/O processor's enable is 1. That enable is bit 0 of offset 0xC written through the I/O-processor port.
- R10: The host interrupt is high while flag bit 2 is set and the host's enable is 1. That enable is bit 0 of offset 0xC written through the host port. Each port reads back its own enable.
- R11: Address bits at and above the window size (2^WIN_BITS bytes) are ignored, so the registers are mirrored across the address range.
- R12: Offsets inside the window other than 0x0, 0x4, 0x8 and 0xC read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| h_req_i | input | 1 | Host access strobe |
| h_we_i | input | 1 | Host write enable |
| h_addr_i | input | ADDR_W | Host byte address |
| h_wdata_i | input | DATA_W | Host write data |
| h_rdata_o | output | DATA_W | Host read data, combinational from the address |
| io_req_i | input | 1 | I/O-processor access strobe |
| io_we_i | input | 1 | I/O-processor write enable |
| io_addr_i | input | ADDR_W | I/O-processor byte address |
| io_wdata_i | input | DATA_W | I/O-processor write data |
| io_rdata_o | output | DATA_W | I/O-processor read data, combinational from the address |
| host_irq_o | output | 1 | Reply interrupt to the host |
| iop_irq_o | output | 1 | Request interrupt to the I/O processor |

## Verification
The bench builds the block with ADDR_W=12 and WIN_BITS=8. The window is then 0x100 bytes and repeats sixteen times in the port address space. Accesses at 0x104 and 0xF00 therefore reach real mirrors, and offset 0x10 falls inside the window as an unmapped word. The flag width and masks stay at their defaults, so the bit ownership and the 0x14 reply value are exercised exactly as specified, including writes from both ports to the flag register in the same cycle.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;
  // word indices inside the window (byte offset >> 2)
  localparam int unsigned WRD_REQ = 0;
  localparam int unsigned WRD_FLG = 1;
  localparam int unsigned WRD_REP = 2;
  localparam int unsigned WRD_EN  = 3;

  typedef struct packed {
    logic req_ptr;
    logic flags;
    logic rep_ptr;
    logic irq_en;
  } sel_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import ipc_mbx_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int WIN_BITS = 10
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output sel_t              hit_o,
  output sel_t              wr_o
);
  localparam int WW = WIN_BITS - 2;

  logic [WW-1:0] word;
  logic          unused_addr;

  // upper bits dropped on purpose: mirrored window
  assign word        = addr_i[WIN_BITS-1:2];
  assign unused_addr = ^{addr_i[ADDR_W-1:WIN_BITS], addr_i[1:0]};

  always_comb begin
    hit_o.req_ptr = (word == WW'(WRD_REQ));
    hit_o.flags   = (word == WW'(WRD_FLG));
    hit_o.rep_ptr = (word == WW'(WRD_REP));
    hit_o.irq_en  = (word == WW'(WRD_EN));
    wr_o          = (req_i && we_i) ? hit_o : '0;
  end
endmodule

// File: rtl/mbx_ptr.sv
module mbx_ptr #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          q_o <= '0;
    else if (wr_i && wdata_i[1:0] == 2'b00) q_o <= wdata_i;
  end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
  parameter int                FLAG_W    = 8,
  parameter logic [FLAG_W-1:0] HOST_MASK = 8'h03,
  parameter logic [FLAG_W-1:0] IOP_MASK  = 8'hFC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              h_wr_i,
  input  logic [FLAG_W-1:0] h_data_i,
  input  logic              io_wr_i,
  input  logic [FLAG_W-1:0] io_data_i,
  output logic [FLAG_W-1:0] q_o
);
  logic [FLAG_W-1:0] set_v, clr_v;

  // owner sets its bits, receiver clears them (write-1)
  always_comb begin
    set_v = '0;
    clr_v = '0;
    if (h_wr_i) begin
      set_v = set_v | (h_data_i & HOST_MASK);
      clr_v = clr_v | (h_data_i & IOP_MASK);
    end
    if (io_wr_i) begin
      set_v = set_v | (io_data_i & IOP_MASK);
      clr_v = clr_v | (io_data_i & HOST_MASK);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_v) | set_v;  // set dominates
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_mbx_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                WIN_BITS  = 10,
  parameter int                DATA_W    = 32,
  parameter int                FLAG_W    = 8,
  parameter logic [FLAG_W-1:0] HOST_MASK = 8'h03,
  parameter logic [FLAG_W-1:0] IOP_MASK  = 8'hFC,
  parameter int                REQ_BIT   = 0,
  parameter int                REPLY_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              h_req_i,
  input  logic              h_we_i,
  input  logic [ADDR_W-1:0] h_addr_i,
  input  logic [DATA_W-1:0] h_wdata_i,
  output logic [DATA_W-1:0] h_rdata_o,
  input  logic              io_req_i,
  input  logic              io_we_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  output logic              host_irq_o,
  output logic              iop_irq_o
);
  localparam int NSIDE = 2;  // 0: host, 1: I/O processor

  logic [NSIDE-1:0] req_a, we_a;
  logic [ADDR_W-1:0] addr_a [NSIDE];
  logic [DATA_W-1:0] wdata_a [NSIDE];
  sel_t hit_a [NSIDE];
  sel_t wr_a  [NSIDE];

  logic [DATA_W-1:0] req_ptr_q, rep_ptr_q;
  logic [FLAG_W-1:0] flags_q;

  assign req_a      = {io_req_i, h_req_i};
  assign we_a       = {io_we_i, h_we_i};
  assign addr_a[0]  = h_addr_i;
  assign addr_a[1]  = io_addr_i;
  assign wdata_a[0] = h_wdata_i;
  assign wdata_a[1] = io_wdata_i;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    logic              en_q;
    logic [DATA_W-1:0] rd_d;

    mbx_decode #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_dec (
      .req_i (req_a[s]),
      .we_i  (we_a[s]),
      .addr_i(addr_a[s]),
      .hit_o (hit_a[s]),
      .wr_o  (wr_a[s])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             en_q <= 1'b0;
      else if (wr_a[s].irq_en) en_q <= wdata_a[s][0];
    end

    always_comb begin
      rd_d = '0;
      if (hit_a[s].req_ptr)      rd_d = req_ptr_q;
      else if (hit_a[s].flags)   rd_d = {{(DATA_W-FLAG_W){1'b0}}, flags_q};
      else if (hit_a[s].rep_ptr) rd_d = rep_ptr_q;
      else if (hit_a[s].irq_en)  rd_d = {{(DATA_W-1){1'b0}}, en_q};
    end
  end

  mbx_ptr #(.DATA_W(DATA_W)) u_req_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_a[0].req_ptr),
    .wdata_i(h_wdata_i),
    .q_o    (req_ptr_q)
  );

  mbx_ptr #(.DATA_W(DATA_W)) u_rep_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_a[1].rep_ptr),
    .wdata_i(io_wdata_i),
    .q_o    (rep_ptr_q)
  );

  mbx_flags #(.FLAG_W(FLAG_W), .HOST_MASK(HOST_MASK), .IOP_MASK(IOP_MASK)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .h_wr_i   (wr_a[0].flags),
    .h_data_i (h_wdata_i[FLAG_W-1:0]),
    .io_wr_i  (wr_a[1].flags),
    .io_data_i(io_wdata_i[FLAG_W-1:0]),
    .q_o      (flags_q)
  );

  assign h_rdata_o  = g_side[0].rd_d;
  assign io_rdata_o = g_side[1].rd_d;
  assign host_irq_o = flags_q[REPLY_BIT] & g_side[0].en_q;
  assign iop_irq_o  = flags_q[REQ_BIT]   & g_side[1].en_q;
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
  parameter int                ADDR_W    = 16,
  parameter int                WIN_BITS  = 10,
  parameter int                DATA_W    = 32,
  parameter int                FLAG_W    = 8,
  parameter logic [FLAG_W-1:0] IOP_MASK  = 8'hFC,
  parameter int                REQ_BIT   = 0,
  parameter int                REPLY_BIT = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              h_req_i,
  input logic              h_we_i,
  input logic [ADDR_W-1:0] h_addr_i,
  input logic [DATA_W-1:0] h_wdata_i,
  input logic              io_req_i,
  input logic              io_we_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic [DATA_W-1:0] io_wdata_i,
  input logic              host_irq_o,
  input logic              iop_irq_o,
  input logic [DATA_W-1:0] req_ptr_q,
  input logic [FLAG_W-1:0] flags_q
);
  localparam int WW = WIN_BITS - 2;

  logic [WW-1:0] h_w, io_w;
  logic h_wr0, h_wr1, io_wr0, io_wr1;
  logic [FLAG_W-1:0] io_set;
  logic unused_chk;

  assign h_w    = h_addr_i[WIN_BITS-1:2];
  assign io_w   = io_addr_i[WIN_BITS-1:2];
  assign h_wr0  = h_req_i && h_we_i && h_w == WW'(0);
  assign h_wr1  = h_req_i && h_we_i && h_w == WW'(1);
  assign io_wr0 = io_req_i && io_we_i && io_w == WW'(0);
  assign io_wr1 = io_req_i && io_we_i && io_w == WW'(1);
  assign io_set = io_wdata_i[FLAG_W-1:0] & IOP_MASK;
  assign unused_chk = ^{h_addr_i[ADDR_W-1:WIN_BITS], h_addr_i[1:0],
                        io_addr_i[ADDR_W-1:WIN_BITS], io_addr_i[1:0],
                        io_wdata_i[DATA_W-1:FLAG_W], h_wdata_i[DATA_W-1:FLAG_W]};

  // R2
  req_ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_wr0 && h_wdata_i[1:0] == 2'b00) |=> req_ptr_q == $past(h_wdata_i));

  // R3
  misaligned_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_wr0 && h_wdata_i[1:0] != 2'b00) |=> $stable(req_ptr_q));

  // R4
  foreign_req_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr0 && !h_wr0) |=> $stable(req_ptr_q));

  // R6
  reply_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr1 |=> (flags_q & $past(io_set)) == $past(io_set));

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_wr1 && h_wdata_i[REQ_BIT]) |=> flags_q[REQ_BIT]);

  // R7
  req_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr1 && io_wdata_i[REQ_BIT] && !(h_wr1 && h_wdata_i[REQ_BIT]))
      |=> (!flags_q[REQ_BIT] && !iop_irq_o));

  // R9
  iop_irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iop_irq_o |-> flags_q[REQ_BIT]);

  // R10
  host_irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |-> flags_q[REPLY_BIT]);
endmodule

bind ipc_mailbox ipc_mailbox_chk #(
  .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .DATA_W(DATA_W), .FLAG_W(FLAG_W),
  .IOP_MASK(IOP_MASK), .REQ_BIT(REQ_BIT), .REPLY_BIT(REPLY_BIT)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .h_req_i   (h_req_i),
  .h_we_i    (h_we_i),
  .h_addr_i  (h_addr_i),
  .h_wdata_i (h_wdata_i),
  .io_req_i  (io_req_i),
  .io_we_i   (io_we_i),
  .io_addr_i (io_addr_i),
  .io_wdata_i(io_wdata_i),
  .host_irq_o(host_irq_o),
  .iop_irq_o (iop_irq_o),
  .req_ptr_q (req_ptr_q),
  .flags_q   (flags_q)
);

// File: tb/ipc_mailbox_test.sv
`timescale 1ns/1ps
module ipc_mailbox_test;
  localparam int AW = 12;
  localparam int WB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_req = 0, h_we = 0, io_req = 0, io_we = 0;
  logic [AW-1:0] h_addr = '0, io_addr = '0;
  logic [31:0] h_wdata = '0, io_wdata = '0, h_rdata, io_rdata;
  logic host_irq, iop_irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // scoreboard: kind 0 host read, 1 io read, 2 host irq, 3 io irq
  int          kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  ipc_mailbox #(.ADDR_W(AW), .WIN_BITS(WB)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .h_req_i(h_req), .h_we_i(h_we), .h_addr_i(h_addr), .h_wdata_i(h_wdata), .h_rdata_o(h_rdata),
    .io_req_i(io_req), .io_we_i(io_we), .io_addr_i(io_addr), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .host_irq_o(host_irq), .iop_irq_o(iop_irq)
  );

  // monitor
  always @(negedge clk) begin
    if (kind_q.size() != 0) begin
      int k;
      logic [31:0] e, a;
      string t;
      k = kind_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      case (k)
        0: a = h_rdata;
        1: a = io_rdata;
        2: a = {31'b0, host_irq};
        default: a = {31'b0, iop_irq};
      endcase
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, a, e);
      end
    end
  end

  task automatic wr(input bit io, input logic [AW-1:0] a, input logic [31:0] d);
    if (io) begin io_req = 1; io_we = 1; io_addr = a; io_wdata = d; end
    else    begin h_req = 1;  h_we = 1;  h_addr = a;  h_wdata = d;  end
    @(posedge clk); #1;
    h_req = 0; h_we = 0; io_req = 0; io_we = 0;
  endtask

  task automatic wr_both(input logic [AW-1:0] ha, input logic [31:0] hd,
                         input logic [AW-1:0] ia, input logic [31:0] id);
    h_req = 1; h_we = 1; h_addr = ha; h_wdata = hd;
    io_req = 1; io_we = 1; io_addr = ia; io_wdata = id;
    @(posedge clk); #1;
    h_req = 0; h_we = 0; io_req = 0; io_we = 0;
  endtask

  task automatic rd(input bit io, input logic [AW-1:0] a, input logic [31:0] e, input string t);
    if (io) begin io_req = 1; io_we = 0; io_addr = a; end
    else    begin h_req = 1;  h_we = 0;  h_addr = a;  end
    kind_q.push_back(io ? 1 : 0); exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    h_req = 0; io_req = 0;
  endtask

  task automatic irq(input bit io, input logic e, input string t);
    kind_q.push_back(io ? 3 : 2); exp_q.push_back({31'b0, e}); tag_q.push_back(t);
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(0, AW'(i*4), 32'h0, "R1 host reg");
      rd(1, AW'(i*4), 32'h0, "R1 io reg");
    end
    irq(0, 0, "R1 host irq");
    irq(1, 0, "R1 iop irq");

    // R2 request pointer
    wr(0, 12'h000, 32'h1000_0040);
    rd(0, 12'h000, 32'h1000_0040, "R2 host req ptr");
    rd(1, 12'h000, 32'h1000_0040, "R2 io req ptr");

    // R3 misaligned
    wr(0, 12'h000, 32'h2000_0002);
    rd(0, 12'h000, 32'h1000_0040, "R3 misaligned bit1");
    wr(0, 12'h000, 32'h2000_0001);
    rd(1, 12'h000, 32'h1000_0040, "R3 misaligned bit0");

    // R4 ownership
    wr(1, 12'h000, 32'h3000_0000);
    rd(0, 12'h000, 32'h1000_0040, "R4 io write req ptr");
    wr(0, 12'h008, 32'h0000_0044);
    rd(1, 12'h008, 32'h0, "R4 host write rep ptr");

    // R9 enable, per-port readback (R10)
    wr(1, 12'h00C, 32'h1);
    rd(1, 12'h00C, 32'h1, "R9 io enable");
    rd(0, 12'h00C, 32'h0, "R10 host enable separate");

    // R5 doorbell
    wr(0, 12'h004, 32'h1);
    rd(1, 12'h004, 32'h01, "R5 doorbell set");
    irq(1, 1, "R9 iop irq raised");
    wr(0, 12'h004, 32'h0);
    rd(0, 12'h004, 32'h01, "R5 zero write no effect");

    // reply path R2 R6 R7
    wr(1, 12'h008, 32'h1000_0040);
    rd(0, 12'h008, 32'h1000_0040, "R2 reply ptr");
    wr(1, 12'h004, 32'h15);
    rd(0, 12'h004, 32'h14, "R6/R7 reply set and ack");
    irq(1, 0, "R7 iop irq dropped");
    irq(0, 0, "R10 host irq masked");

    // R10 host enable
    wr(0, 12'h00C, 32'hFFFF_FFFF);
    rd(0, 12'h00C, 32'h1, "R10 host enable");
    irq(0, 1, "R10 host irq raised");
    wr(0, 12'h004, 32'h04);
    rd(1, 12'h004, 32'h10, "R7 host clears reply bit");
    irq(0, 0, "R10 host irq dropped");
    wr(0, 12'h004, 32'h10);
    rd(0, 12'h004, 32'h00, "R7 host clears bit4");

    // R8 same-cycle
    wr_both(12'h004, 32'h1, 12'h004, 32'h1);
    rd(0, 12'h004, 32'h01, "R8 host set vs io clear");
    wr_both(12'h004, 32'h04, 12'h004, 32'h14);
    rd(1, 12'h004, 32'h15, "R8 io set vs host clear");
    irq(0, 1, "R8 host irq after set win");

    // R11 mirroring
    rd(0, 12'h104, 32'h15, "R11 mirror read");
    wr(0, 12'hF00, 32'h0000_0080);
    rd(0, 12'h000, 32'h0000_0080, "R11 mirror write");
    rd(1, 12'hA08, 32'h1000_0040, "R11 io mirror read");

    // R12 unmapped
    wr(0, 12'h010, 32'hFFFF_FFFF);
    rd(0, 12'h010, 32'h0, "R12 unmapped read");
    rd(0, 12'h004, 32'h15, "R12 flags untouched");
    rd(0, 12'h000, 32'h0000_0080, "R12 req ptr untouched");
    wr(1, 12'h0FC, 32'hFFFF_FFFF);
    rd(1, 12'h0FC, 32'h0, "R12 io unmapped read");
    rd(1, 12'h00C, 32'h1, "R12 io enable untouched");

    @(posedge clk); #1;
    done = 1;
    summary();
    $finish;
  end
endmodule